// File: doc/BRIEF.md
# Soft Reset and FIFO Flush Sequencer

This block owns one control register whose command bits start timed housekeeping operations in the surrounding datapath. The operations are: flush the transmit queue, flush the receive queue, zero the frame counter at the next start-of-frame, reset the bus-side state machines, and reset the whole core. Software sets a command bit by writing a 1 to it. The bit then stays high while its strobe output is driven, and it clears itself when the operation is over. Software polls the bit to learn when the operation has finished.

A flush is accepted only when the matching queue reports that it is not busy. Each finished flush also gives a one-cycle completion pulse. The top bit of the register tells the bus master whether the bus side is idle. The whole block runs in a single clock domain with a synchronous, active-high reset.

Top module: `rstseq_ctrl`

## Requirements
- R1: After reset every command bit reads 0 and every strobe and pulse output is low. Bit 31 of `rd_data` reads 1 when `bus_xfer_active` is low.
- R2: A write with bit 4 set, accepted while `tx_fifo_busy` is low, sets bit 4 and `tx_flush` in the cycle after the write edge. Both stay high for exactly FLUSH_CYC cycles (default 8) and then clear.
- R3: In the cycle right after a flush bit clears on completion, the matching done output (`tx_flush_done` or `rx_flush_done`) is high for exactly one cycle.
- R4: Bit 3 with `rx_fifo_busy` behaves like R2 and drives `rx_flush`. It is independent of the transmit flush.
- R5: A flush write made while the matching busy input is high is ignored. The bit stays 0, no strobe appears and no done pulse appears.
- R6: Writing 1 to a command bit that is already set does not restart its timing. Writing 0 never clears a bit early.
- R7: Writing bit 2 sets it and `frame_num_clr`. The bit clears at the first clock edge at which `sof_strobe` is high while the bit is set.
- R8: Writing bit 1 sets it and `bus_soft_rst`. The bit clears after BUS_CYC (default 4) clock edges at which `bus_xfer_active` was low, so the count pauses while the bus is busy. A running flush is not affected by it.
- R9: Writing bit 0 sets it and `core_soft_rst` for exactly CORE_CYC cycles (default 16). Its start cancels every other command bit without a done pulse. Other writes made while it runs, or in the same write as it, are ignored.
- R10: Bit 31 of `rd_data` equals NOT `bus_xfer_active` AND NOT bit 1 AND NOT bit 0. All bits other than 0 to 4 and 31 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data; a 1 in a command bit starts that command |
| rd_data | output | 32 | Register read value |
| tx_fifo_busy | input | 1 | Transmit queue is being read or written |
| rx_fifo_busy | input | 1 | Receive queue is being read or written |
| sof_strobe | input | 1 | Start-of-frame pulse from the frame timer |
| bus_xfer_active | input | 1 | Bus master has a transfer in flight |
| tx_flush | output | 1 | Transmit queue flush strobe |
| rx_flush | output | 1 | Receive queue flush strobe |
| tx_flush_done | output | 1 | One-cycle transmit flush completion pulse |
| rx_flush_done | output | 1 | One-cycle receive flush completion pulse |
| frame_num_clr | output | 1 | Frame number is zeroed at the next start-of-frame |
| bus_soft_rst | output | 1 | Reset of the bus-side state machines |
| core_soft_rst | output | 1 | Reset of the whole core |

## Verification
A hold counter that is off by one shows up as a command bit and strobe that clear one cycle early or late. It also shows up as a done pulse on the wrong cycle. The bench sees this as soon as the operation ends, because it compares the strobes against an expected model on every cycle. A gating error is visible in the cycle after the offending write. Such errors include accepting a flush while busy, restarting a running command, or a missed cancellation by the core reset. A wrong idle term shows at once on bit 31, with no clock edge needed.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned CMD_CORE  = 0;
  localparam int unsigned CMD_BUS   = 1;
  localparam int unsigned CMD_FRAME = 2;
  localparam int unsigned CMD_RXFL  = 3;  // receive flush; transmit flush is the next bit
  localparam int unsigned CMD_TXFL  = 4;
  localparam int unsigned IDLE_BIT  = 31;
  localparam int unsigned NUM_FIFO  = 2;  // index 0 receive, 1 transmit

  typedef struct packed {
    logic txfl;
    logic rxfl;
    logic frame;
    logic bus;
    logic core;
  } cmd_bits_t;
endpackage

// File: rtl/rstseq_cmd_timer.sv
module rstseq_cmd_timer #(
  parameter int unsigned HOLD_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic advance_i,
  input  logic abort_i,
  output logic active_o,
  output logic done_o
);
  localparam int unsigned CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [CW-1:0] LOAD = CW'(HOLD_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_o <= 1'b0;
      done_o   <= 1'b0;
      cnt_q    <= '0;
    end else begin
      done_o <= 1'b0;
      if (abort_i) begin
        active_o <= 1'b0;
      end else if (active_o) begin
        if (advance_i) begin
          if (cnt_q == '0) begin
            active_o <= 1'b0;
            done_o   <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
      end else if (start_i) begin
        active_o <= 1'b1;
        cnt_q    <= LOAD;
      end
    end
  end

  AST_DONE_ENDS_HOLD: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!active_o && $past(active_o)));  // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);  // R3
endmodule

// File: rtl/rstseq_frame_clr.sv
module rstseq_frame_clr (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic sof_i,
  input  logic abort_i,
  output logic pend_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_o <= 1'b0;
    end else if (abort_i) begin
      pend_o <= 1'b0;
    end else if (pend_o) begin
      if (sof_i) pend_o <= 1'b0;
    end else if (set_i) begin
      pend_o <= 1'b1;
    end
  end

  AST_FRAME_CLR_ON_SOF: assert property (@(posedge clk) disable iff (rst)
    (pend_o && sof_i) |=> !pend_o);  // R7
  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pend_o && !sof_i && !abort_i) |=> pend_o);  // R7
endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
  import rstseq_pkg::*;
#(
  parameter int unsigned FLUSH_CYC = 8,
  parameter int unsigned BUS_CYC   = 4,
  parameter int unsigned CORE_CYC  = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic        tx_fifo_busy,
  input  logic        rx_fifo_busy,
  input  logic        sof_strobe,
  input  logic        bus_xfer_active,
  output logic        tx_flush,
  output logic        rx_flush,
  output logic        tx_flush_done,
  output logic        rx_flush_done,
  output logic        frame_num_clr,
  output logic        bus_soft_rst,
  output logic        core_soft_rst
);
  cmd_bits_t cmd;
  logic      core_start;
  logic      wr_ok;
  logic      core_done;
  logic      bus_done;
  logic [NUM_FIFO-1:0] q_busy;
  logic [NUM_FIFO-1:0] q_flush;
  logic [NUM_FIFO-1:0] q_done;

  assign core_start = wr_en && wr_data[CMD_CORE] && !core_soft_rst;
  assign wr_ok      = wr_en && !core_soft_rst && !core_start;
  assign q_busy     = {tx_fifo_busy, rx_fifo_busy};

  rstseq_cmd_timer #(.HOLD_CYC(CORE_CYC)) u_core (
    .clk(clk), .rst(rst), .start_i(core_start), .advance_i(1'b1),
    .abort_i(1'b0), .active_o(core_soft_rst), .done_o(core_done));

  rstseq_cmd_timer #(.HOLD_CYC(BUS_CYC)) u_bus (
    .clk(clk), .rst(rst), .start_i(wr_ok && wr_data[CMD_BUS]),
    .advance_i(!bus_xfer_active), .abort_i(core_start),
    .active_o(bus_soft_rst), .done_o(bus_done));

  rstseq_frame_clr u_frame (
    .clk(clk), .rst(rst), .set_i(wr_ok && wr_data[CMD_FRAME]),
    .sof_i(sof_strobe), .abort_i(core_start), .pend_o(frame_num_clr));

  for (genvar g = 0; g < NUM_FIFO; g++) begin : g_flush
    rstseq_cmd_timer #(.HOLD_CYC(FLUSH_CYC)) u_fl (
      .clk(clk), .rst(rst),
      .start_i(wr_ok && wr_data[CMD_RXFL + g] && !q_busy[g]),
      .advance_i(1'b1), .abort_i(core_start),
      .active_o(q_flush[g]), .done_o(q_done[g]));
  end

  assign rx_flush      = q_flush[0];
  assign tx_flush      = q_flush[1];
  assign rx_flush_done = q_done[0];
  assign tx_flush_done = q_done[1];

  assign cmd = '{txfl: tx_flush, rxfl: rx_flush, frame: frame_num_clr,
                 bus: bus_soft_rst, core: core_soft_rst};

  always_comb begin
    rd_data = '0;
    rd_data[CMD_TXFL:CMD_CORE] = cmd;
    rd_data[IDLE_BIT] = !bus_xfer_active && !bus_soft_rst && !core_soft_rst;
  end

  AST_TX_BUSY_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[CMD_TXFL] && tx_fifo_busy && !tx_flush) |=> !tx_flush);  // R5
  AST_RX_BUSY_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[CMD_RXFL] && rx_fifo_busy && !rx_flush) |=> !rx_flush);  // R5
  AST_CORE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    core_soft_rst |-> !(tx_flush || rx_flush || bus_soft_rst || frame_num_clr));  // R9
  AST_CORE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    core_done |-> !core_soft_rst);  // R9
  AST_BUS_PAUSE: assert property (@(posedge clk) disable iff (rst)
    (bus_soft_rst && bus_xfer_active && !(wr_en && wr_data[CMD_CORE])) |=> bus_soft_rst);  // R8
  AST_BUS_RELEASE: assert property (@(posedge clk) disable iff (rst)
    bus_done |-> !bus_soft_rst);  // R8
endmodule

// File: tb/rstseq_ctrl_tb.sv
module rstseq_ctrl_tb_top;
  localparam int FL = 8;
  localparam int BC = 4;
  localparam int CC = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic tx_b = 1'b0, rx_b = 1'b0, sof = 1'b0, bact = 1'b0;
  logic [31:0] rd_data;
  logic tx_fl, rx_fl, tx_dn, rx_dn, fr_clr, bus_r, core_r;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // expected state: remaining cycles per command, frame pending, done pulses
  int m_tx = 0, m_rx = 0, m_bus = 0, m_core = 0;
  bit m_fr = 0, m_txd = 0, m_rxd = 0;

  always #4 clk = ~clk;

  rstseq_ctrl #(.FLUSH_CYC(FL), .BUS_CYC(BC), .CORE_CYC(CC)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .tx_fifo_busy(tx_b), .rx_fifo_busy(rx_b), .sof_strobe(sof),
    .bus_xfer_active(bact), .tx_flush(tx_fl), .rx_flush(rx_fl),
    .tx_flush_done(tx_dn), .rx_flush_done(rx_dn), .frame_num_clr(fr_clr),
    .bus_soft_rst(bus_r), .core_soft_rst(core_r));

  function automatic logic [31:0] exp_rd();
    logic [31:0] v = '0;
    v[4] = (m_tx != 0);
    v[3] = (m_rx != 0);
    v[2] = m_fr;
    v[1] = (m_bus != 0);
    v[0] = (m_core != 0);
    v[31] = !bact && (m_bus == 0) && (m_core == 0);
    return v;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  // model update at a clock edge, from the inputs held over that edge
  task automatic model_edge();
    bit cs;
    m_txd = 0; m_rxd = 0;
    if (rst) begin
      m_tx = 0; m_rx = 0; m_bus = 0; m_core = 0; m_fr = 0;
      return;
    end
    cs = wr_en && wr_data[0] && (m_core == 0);
    if (m_core != 0) begin
      m_core--;
    end else if (cs) begin
      m_core = CC; m_tx = 0; m_rx = 0; m_bus = 0; m_fr = 0;
    end else begin
      if (m_tx != 0) begin m_tx--; m_txd = (m_tx == 0); end
      else if (wr_en && wr_data[4] && !tx_b) m_tx = FL;
      if (m_rx != 0) begin m_rx--; m_rxd = (m_rx == 0); end
      else if (wr_en && wr_data[3] && !rx_b) m_rx = FL;
      if (m_bus != 0) begin if (!bact) m_bus--; end
      else if (wr_en && wr_data[1]) m_bus = BC;
      if (m_fr) begin if (sof) m_fr = 0; end
      else if (wr_en && wr_data[2]) m_fr = 1;
    end
  endtask

  task automatic check_all();
    chk("R2 tx_flush", {31'd0, tx_fl}, {31'd0, m_tx != 0});
    chk("R4 rx_flush", {31'd0, rx_fl}, {31'd0, m_rx != 0});
    chk("R3 tx_flush_done", {31'd0, tx_dn}, {31'd0, m_txd});
    chk("R3 rx_flush_done", {31'd0, rx_dn}, {31'd0, m_rxd});
    chk("R7 frame_num_clr", {31'd0, fr_clr}, {31'd0, m_fr});
    chk("R8 bus_soft_rst", {31'd0, bus_r}, {31'd0, m_bus != 0});
    chk("R9 core_soft_rst", {31'd0, core_r}, {31'd0, m_core != 0});
    chk("R10 rd_data", rd_data, exp_rd());
  endtask

  task automatic step(bit w, logic [31:0] d, bit tb, bit rb, bit s, bit ba);
    wr_en = w; wr_data = d; tx_b = tb; rx_b = rb; sof = s; bact = ba;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_all();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, '0, 0, 0, 0, 0);
  endtask

  initial begin
    void'($urandom(32'd20250611));
    @(negedge clk);
    step(0, '0, 0, 0, 0, 0);
    step(0, '0, 0, 0, 0, 0);
    rst = 1'b0;
    // R1 reset state
    chk("R1 rd_data after reset", rd_data, 32'h8000_0000);
    chk("R1 strobes after reset", {25'd0, tx_fl, rx_fl, tx_dn, rx_dn, fr_clr, bus_r, core_r}, '0);
    idle(2);
    // R2/R3 transmit flush length and done pulse
    step(1, 32'h10, 0, 0, 0, 0);
    idle(FL + 2);
    // R4 receive flush alongside transmit flush
    step(1, 32'h18, 0, 0, 0, 0);
    idle(3);
    // R6 rewrite while active and write of zero
    step(1, 32'h18, 0, 0, 0, 0);
    step(1, 32'h00, 0, 0, 0, 0);
    idle(FL);
    // R5 busy gating
    step(1, 32'h18, 1, 1, 0, 0);
    idle(3);
    step(1, 32'h10, 1, 0, 0, 0);
    idle(FL + 1);
    // R7 frame clear waits for start-of-frame
    step(1, 32'h04, 0, 0, 0, 0);
    idle(4);
    step(1, 32'h04, 0, 0, 1, 0);
    idle(2);
    // R8 bus reset paused by bus activity, flush unaffected
    step(1, 32'h12, 0, 0, 0, 1);
    for (int i = 0; i < 5; i++) step(0, '0, 0, 0, 0, 1);
    idle(BC + 2);
    // R9 core reset cancels running commands, later writes ignored
    step(1, 32'h1E, 0, 0, 0, 0);
    idle(2);
    step(1, 32'h01, 0, 0, 0, 0);
    step(1, 32'h1F, 0, 0, 0, 0);
    idle(CC + 2);
    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] d = $urandom;
      d[0] = ($urandom % 60) == 0;
      step(($urandom % 5) == 0, d, ($urandom % 3) == 0, ($urandom % 3) == 0,
           ($urandom % 16) == 0, ($urandom % 3) == 0);
    end
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule